// File: doc/BRIEF.md
# Home-Address Track Write Sequencer

This block steers a format-level write of one disc track that begins at the home-address area. A write command starts a preparation cycle. In service mode, where both the operator switch and the service switch are on, the sequencer copies the character held in record register slot 0 toward the serial register. It then issues a head-load pulse, and any flag bits in that character send the write to an alternate track. With the service switch off, both of these actions are suppressed and slot 0 may hold any character.

After the first index, the block chooses what the write circuits put on the track. In service mode it writes all-ones filler up to the home-address area and then writes data. In customer mode it stays quiet until the first home address has been verified and then writes data. Blanks go out in the gap digits at the end of each check area, and in every remaining area once the host has asked to stop.

When the last check area ends, filler is written until the sixth digit time of the second index, and a one-cycle done pulse closes the operation. A flagged home address in service mode switches to filler at the gap digit of its check area, and filler then runs to the end of the track. A customer verify that never compares also ends at the second index.

Top module: `hawr_seq`

## Requirements
- R1: While reset is high and after it, with no command, wmode is 00 and head_load, xfer_stb, alt_trk and done are 0.
- R2: A start pulse while sw_op is 0 is ignored: wmode stays 00 and no pulse is issued on head_load, xfer_stb or done.
- R3: In service mode (sw_op and sw_svc both 1), during preparation, a digit strobe with digit 3 gives a one-cycle xfer_stb on the next cycle, with xfer_char equal to slot0. A digit strobe with digit 4 gives a one-cycle head_load on the next cycle.
- R4: With sw_svc 0, preparation produces neither xfer_stb nor head_load, and alt_trk stays 0 whatever slot0 holds.
- R5: alt_trk is set at the transfer when any of the flag bits of slot0 (bits 2, 1, 0, the BCD 4, 2 and 1 bits) is 1. A blank (0) or an eight (bit 3 only) leaves it 0.
- R6: In service mode, from the cycle after the first index pulse until ha_area is seen, wmode is 11 (filler).
- R7: In customer mode, wmode stays 00 after the first index until cmp_true. From the next cycle it is 01 (data).
- R8: While writing, a cycle with chk_area high and digit 5 or 6 gives wmode 10 (blank) on the next cycle. Other cycles give 01.
- R9: A stop_req while writing makes wmode 10 in every following writing cycle, until the last check area ends.
- R10: last_chk_end while writing gives wmode 11 from the next cycle. Filler then holds until a digit-6 strobe with idx2. After that strobe, done is high for exactly one cycle and wmode returns to 00.
- R11: In service mode with alt_trk set, a digit-5 strobe while ha_area and chk_area are both high gives wmode 11 on the next cycle, and filler holds to the second-index end of R10.
- R12: In customer mode, a digit-6 strobe with idx2 before any cmp_true ends the operation with a one-cycle done and wmode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Write command pulse |
| sw_op | input | 1 | Operator home-address switch |
| sw_svc | input | 1 | Service switch |
| slot0 | input | CHR_W | Record register slot 0 character |
| dstb | input | 1 | Digit-time strobe |
| digit | input | DIG_W | Current digit number |
| idx1 | input | 1 | First index pulse |
| idx2 | input | 1 | Second index in progress |
| ha_area | input | 1 | Home-address area one, check area included |
| chk_area | input | 1 | Check area in progress |
| last_chk_end | input | 1 | End of last check area pulse |
| cmp_true | input | 1 | Home address compared true |
| stop_req | input | 1 | Host stop or disconnect |
| wmode | output | 2 | 00 idle, 01 data, 10 blank, 11 filler |
| head_load | output | 1 | Head register load pulse |
| xfer_stb | output | 1 | Slot 0 transfer pulse |
| xfer_char | output | CHR_W | Character moved to the serial register |
| alt_trk | output | 1 | Alternate track selected |
| done | output | 1 | Operation end pulse |

## Verification
The bench builds the block with its defaults: six-bit characters, a three-bit digit number and seven digit times. With these values, the transfer, head-load, gap and end-of-track digits all fall inside one short strobe sequence. Blank, eight and flagged slot 0 values, together with both switch settings, can then be driven in a few hundred cycles. A behavioural model advances with the same strobes and is compared with every output on every clock. Named spot checks also cover the flag redirect, the stop blanks and the verify-without-compare end.

// File: rtl/hawr_pkg.sv
package hawr_pkg;
  typedef enum logic [1:0] {
    WM_IDLE  = 2'b00,
    WM_DATA  = 2'b01,
    WM_BLANK = 2'b10,
    WM_FILL  = 2'b11
  } wmode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_ARM, S_LEAD, S_VERIFY, S_WRITE, S_FILL
  } seq_state_t;
endpackage

// File: rtl/hawr_digit_dec.sv
module hawr_digit_dec #(
  parameter int NDIG  = 7,
  parameter int DIG_W = 3
) (
  input  logic             dstb,
  input  logic [DIG_W-1:0] digit,
  output logic [NDIG-1:0]  hit
);
  for (genvar gi = 0; gi < NDIG; gi++) begin : g_hit
    assign hit[gi] = dstb && (digit == DIG_W'(gi));
  end
endmodule

// File: rtl/hawr_flag_latch.sv
module hawr_flag_latch #(
  parameter int              CHR_W     = 6,
  parameter logic [CHR_W-1:0] FLAG_MASK = 6'b000111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cap,
  input  logic [CHR_W-1:0] char_in,
  output logic             xfer_stb,
  output logic [CHR_W-1:0] xfer_char,
  output logic             alt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      xfer_stb  <= 1'b0;
      xfer_char <= '0;
      alt       <= 1'b0;
    end else if (cap) begin
      xfer_stb  <= 1'b1;
      xfer_char <= char_in;
      alt       <= |(char_in & FLAG_MASK);
    end else begin
      xfer_stb  <= 1'b0;
    end
  end
endmodule

// File: rtl/hawr_seq.sv
module hawr_seq #(
  parameter int CHR_W    = 6,
  parameter int DIG_W    = 3,
  parameter int NDIG     = 7,
  parameter int XFER_DIG = 3,
  parameter int LOAD_DIG = 4,
  parameter int GAP_DIG  = 5,
  parameter int END_DIG  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sw_op,
  input  logic             sw_svc,
  input  logic [CHR_W-1:0] slot0,
  input  logic             dstb,
  input  logic [DIG_W-1:0] digit,
  input  logic             idx1,
  input  logic             idx2,
  input  logic             ha_area,
  input  logic             chk_area,
  input  logic             last_chk_end,
  input  logic             cmp_true,
  input  logic             stop_req,
  output logic [1:0]       wmode,
  output logic             head_load,
  output logic             xfer_stb,
  output logic [CHR_W-1:0] xfer_char,
  output logic             alt_trk,
  output logic             done
);
  import hawr_pkg::*;

  localparam logic [CHR_W-1:0] FLAG_MASK = CHR_W'(7);
  localparam logic [DIG_W-1:0] GAP_LO    = DIG_W'(GAP_DIG);
  localparam logic [DIG_W-1:0] GAP_HI    = DIG_W'(END_DIG);

  seq_state_t          state, ns;
  logic [NDIG-1:0]     hit;
  logic                stop_l, stop_n, cap, clr, alt;
  wmode_t              wm_n;

  hawr_digit_dec #(.NDIG(NDIG), .DIG_W(DIG_W)) u_dec (
    .dstb(dstb), .digit(digit), .hit(hit)
  );

  assign clr = (state == S_IDLE) && start && sw_op;
  assign cap = (state == S_PREP) && hit[XFER_DIG] && sw_svc;

  hawr_flag_latch #(.CHR_W(CHR_W), .FLAG_MASK(FLAG_MASK)) u_flag (
    .clk(clk), .rst(rst), .clr(clr), .cap(cap), .char_in(slot0),
    .xfer_stb(xfer_stb), .xfer_char(xfer_char), .alt(alt)
  );
  assign alt_trk = alt;

  assign stop_n = stop_l || ((state == S_WRITE) && stop_req);

  always_comb begin
    ns = state;
    case (state)
      S_IDLE:   if (start && sw_op) ns = S_PREP;
      S_PREP:   if (hit[LOAD_DIG]) ns = S_ARM;
      S_ARM:    if (idx1) ns = sw_svc ? S_LEAD : S_VERIFY;
      S_LEAD:   if (ha_area) ns = S_WRITE;
      S_VERIFY: begin
        if (cmp_true) ns = S_WRITE;
        else if (idx2 && hit[END_DIG]) ns = S_IDLE;
      end
      S_WRITE: begin
        if (sw_svc && alt && ha_area && chk_area && hit[GAP_DIG]) ns = S_FILL;
        else if (last_chk_end) ns = S_FILL;
      end
      S_FILL:   if (idx2 && hit[END_DIG]) ns = S_IDLE;
      default:  ns = S_IDLE;
    endcase
  end

  always_comb begin
    case (ns)
      S_LEAD, S_FILL: wm_n = WM_FILL;
      S_WRITE: begin
        if (stop_n) wm_n = WM_BLANK;
        else if (chk_area && digit >= GAP_LO && digit <= GAP_HI) wm_n = WM_BLANK;
        else wm_n = WM_DATA;
      end
      default: wm_n = WM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      stop_l    <= 1'b0;
      wmode     <= WM_IDLE;
      head_load <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= ns;
      wmode     <= wm_n;
      head_load <= (state == S_PREP) && hit[LOAD_DIG] && sw_svc;
      done      <= ((state == S_FILL) || (state == S_VERIFY)) && (ns == S_IDLE);
      if (clr) stop_l <= 1'b0;
      else if (state == S_WRITE && stop_req) stop_l <= 1'b1;
    end
  end
endmodule

// File: rtl/hawr_seq_chk.sv
module hawr_seq_chk #(
  parameter int CHR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_svc,
  input logic [CHR_W-1:0] xfer_char,
  input logic             xfer_stb,
  input logic             head_load,
  input logic             alt_trk,
  input logic             done,
  input logic [1:0]       wmode
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> wmode == 2'b00);

  p_hl_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    head_load |=> !head_load);

  p_xfer_svc_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> $past(sw_svc));

  p_hl_svc_r4: assert property (@(posedge clk) disable iff (rst)
    head_load |-> $past(sw_svc));

  p_alt_flag_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> (alt_trk == (xfer_char[2:0] != 3'b000)));
endmodule

bind hawr_seq hawr_seq_chk #(.CHR_W(CHR_W)) u_chk (
  .clk(clk), .rst(rst), .sw_svc(sw_svc), .xfer_char(xfer_char),
  .xfer_stb(xfer_stb), .head_load(head_load), .alt_trk(alt_trk),
  .done(done), .wmode(wmode)
);

// File: tb/hawr_seq_bench.sv
module hawr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHR_W = 6;
  localparam int DIG_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, sw_op = 0, sw_svc = 0;
  logic [CHR_W-1:0] slot0 = '0;
  logic dstb = 0;
  logic [DIG_W-1:0] digit = '0;
  logic idx1 = 0, idx2 = 0, ha_area = 0, chk_area = 0;
  logic last_chk_end = 0, cmp_true = 0, stop_req = 0;
  logic [1:0] wmode;
  logic head_load, xfer_stb, alt_trk, done;
  logic [CHR_W-1:0] xfer_char;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hawr_seq u_hawr_seq (
    .clk(clk), .rst(rst), .start(start), .sw_op(sw_op), .sw_svc(sw_svc),
    .slot0(slot0), .dstb(dstb), .digit(digit), .idx1(idx1), .idx2(idx2),
    .ha_area(ha_area), .chk_area(chk_area), .last_chk_end(last_chk_end),
    .cmp_true(cmp_true), .stop_req(stop_req), .wmode(wmode),
    .head_load(head_load), .xfer_stb(xfer_stb), .xfer_char(xfer_char),
    .alt_trk(alt_trk), .done(done)
  );

  // Behavioural model: phase names as integers
  int m_ph = 0;  // 0 idle 1 prep 2 wait index 3 lead filler 4 verify 5 write 6 tail filler
  logic [1:0] m_wm = 0;
  logic m_hl = 0, m_x = 0, m_alt = 0, m_done = 0, m_stop = 0;
  logic [CHR_W-1:0] m_xc = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_wm = 0; m_hl = 0; m_x = 0; m_alt = 0; m_done = 0; m_stop = 0; m_xc = 0;
    end else begin
      m_x = 0; m_hl = 0; m_done = 0;
      if (m_ph == 0) begin
        if (start && sw_op) begin m_ph = 1; m_alt = 0; m_xc = 0; m_stop = 0; end
      end else if (m_ph == 1) begin
        if (dstb && digit == 3 && sw_svc) begin
          m_x = 1; m_xc = slot0; m_alt = (slot0[2:0] != 0);
        end
        if (dstb && digit == 4) begin m_hl = sw_svc; m_ph = 2; end
      end else if (m_ph == 2) begin
        if (idx1) m_ph = sw_svc ? 3 : 4;
      end else if (m_ph == 3) begin
        if (ha_area) m_ph = 5;
      end else if (m_ph == 4) begin
        if (cmp_true) m_ph = 5;
        else if (idx2 && dstb && digit == 6) begin m_ph = 0; m_done = 1; end
      end else if (m_ph == 5) begin
        if (stop_req) m_stop = 1;
        if ((sw_svc && m_alt && ha_area && chk_area && dstb && digit == 5) || last_chk_end)
          m_ph = 6;
      end else if (m_ph == 6) begin
        if (idx2 && dstb && digit == 6) begin m_ph = 0; m_done = 1; end
      end
      if (m_ph == 3 || m_ph == 6) m_wm = 2'b11;
      else if (m_ph == 5) m_wm = (m_stop || (chk_area && (digit == 5 || digit == 6))) ? 2'b10 : 2'b01;
      else m_wm = 2'b00;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "wmode", wmode, m_wm);
      chk(cur_req, "head_load", head_load, m_hl);
      chk(cur_req, "xfer_stb", xfer_stb, m_x);
      chk(cur_req, "xfer_char", xfer_char, m_xc);
      chk(cur_req, "alt_trk", alt_trk, m_alt);
      chk(cur_req, "done", done, m_done);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_digit(int d);
    digit = DIG_W'(d); dstb = 1; step(); dstb = 0;
  endtask

  task automatic prep_seq();
    start = 1; step(); start = 0;
    for (int d = 0; d < 5; d++) begin
      pulse_digit(d);
      if (d == 3) begin
        chk("R3", "xfer_stb after D3", xfer_stb, sw_svc);
        if (sw_svc) chk("R3", "xfer_char", xfer_char, slot0);
        chk("R5", "alt_trk after transfer", alt_trk, sw_svc && (slot0[2:0] != 0));
      end
      if (d == 4) chk("R3", "head_load after D4", head_load, sw_svc);
      step();
    end
  endtask

  task automatic end_track();
    idx2 = 1; step();
    pulse_digit(5); step();
    pulse_digit(6);
    chk("R10", "done at second index D6", done, 1);
    chk("R10", "wmode after end", wmode, 0);
    idx2 = 0; step();
    chk("R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) step();
    chk("R1", "wmode in reset", wmode, 0);
    chk("R1", "done in reset", done, 0);
    rst = 0; step(); step();
    chk("R1", "wmode after reset", wmode, 0);
    chk("R1", "alt_trk after reset", alt_trk, 0);

    // R2: start with operator switch off
    cur_req = "R2";
    sw_op = 0; sw_svc = 1; start = 1; step(); start = 0;
    pulse_digit(3); pulse_digit(4); step();
    chk("R2", "xfer ignored", xfer_stb, 0);
    chk("R2", "head_load ignored", head_load, 0);
    idx1 = 1; step(); idx1 = 0; step();
    chk("R2", "wmode ignored", wmode, 0);

    // Service run, slot0 = eight (no flag)
    cur_req = "R3";
    sw_op = 1; sw_svc = 1; slot0 = 6'b001000;
    prep_seq();
    chk("R5", "eight gives no alternate", alt_trk, 0);
    cur_req = "R6";
    idx1 = 1; step(); idx1 = 0; step();
    chk("R6", "filler before home address", wmode, 3);
    step();
    chk("R6", "filler holds", wmode, 3);
    ha_area = 1; step(); step();
    chk("R6", "data at home address", wmode, 1);
    cur_req = "R8";
    chk_area = 1; digit = 2; step(); step();
    chk("R8", "data in check area digit 2", wmode, 1);
    pulse_digit(5); step();
    chk("R8", "blank check digit 5", wmode, 2);
    digit = 6; step(); step();
    chk("R8", "blank check digit 6", wmode, 2);
    chk_area = 0; ha_area = 0; digit = 0; step(); step();
    chk("R8", "data after check area", wmode, 1);
    cur_req = "R10";
    last_chk_end = 1; step(); last_chk_end = 0;
    chk("R10", "filler after last check", wmode, 3);
    step(); step();
    chk("R10", "filler holds", wmode, 3);
    end_track();

    // Service run with flag character (BCD 2 bit)
    cur_req = "R11";
    slot0 = 6'b000010;
    prep_seq();
    chk("R5", "flag gives alternate", alt_trk, 1);
    idx1 = 1; step(); idx1 = 0;
    ha_area = 1; step(); step();
    chk_area = 1; pulse_digit(3); step();
    chk("R11", "data before gap digit", wmode, 1);
    pulse_digit(5);
    chk("R11", "filler at flagged gap", wmode, 3);
    chk_area = 0; ha_area = 0; step(); step();
    chk("R11", "filler holds rest of track", wmode, 3);
    end_track();

    // Customer run: flag bits in slot0 have no effect
    cur_req = "R4";
    sw_svc = 0; slot0 = 6'b000111;
    prep_seq();
    chk("R4", "no alternate in customer mode", alt_trk, 0);
    chk("R4", "no head_load", head_load, 0);
    cur_req = "R7";
    idx1 = 1; step(); idx1 = 0; step();
    chk("R7", "quiet while verifying", wmode, 0);
    cmp_true = 1; step(); cmp_true = 0;
    chk("R7", "data after compare", wmode, 1);
    step();
    cur_req = "R9";
    stop_req = 1; step(); stop_req = 0;
    chk("R9", "blank on stop", wmode, 2);
    step(); step();
    chk("R9", "blank persists", wmode, 2);
    last_chk_end = 1; step(); last_chk_end = 0;
    chk("R9", "filler after stop at last check", wmode, 3);
    cur_req = "R10";
    end_track();

    // Customer verify never compares
    cur_req = "R12";
    prep_seq();
    idx1 = 1; step(); idx1 = 0; step(); step();
    idx2 = 1; pulse_digit(6);
    chk("R12", "done without compare", done, 1);
    chk("R12", "wmode idle", wmode, 0);
    idx2 = 0; step();
    chk("R12", "done one cycle", done, 0);

    step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule